// File: doc/BRIEF.md
# SMBus Register Slave with Bus-Release Timeout

This block is a target on a two-wire system management bus. Its 7-bit address is set by a parameter. It gives a host access to an 8-bit register space through an address pointer that persists between transfers. SCL and SDA are brought into the system clock domain. Each line passes through a two-flop synchroniser and a short stability filter, and the block then detects bus conditions from the filtered levels. SDA is pulled low through an open-drain enable whenever the block acknowledges a byte or sends a zero bit.

Three transfer forms are supported:
- A write of one byte loads the pointer.
- A write of two bytes loads the pointer and then stores data at the new pointer.
- A read returns the byte at the current pointer.

While an external alert is pending, the block also answers a read to the alert response address and returns its own address. After the last data byte it can append a CRC-8 packet check byte. If the bus stays silent for a programmable number of system clocks, it releases the bus.

The register file side is plain and has no back-pressure. `reg_wr` and `reg_rd` are single-cycle strobes. `reg_addr` always shows the pointer. `reg_rdata` must be a combinational function of `reg_addr`, valid in the cycle `reg_rd` is high. There is no valid/ready handshake: bus timing is set by the host, and clock stretching is not offered.

Top module: `smb_regslave`

## Requirements
- R1: A START followed by address byte 0x98 (write) or 0x99 (read) is acknowledged. Any other address byte gets no acknowledge, and the transfer causes no `reg_wr` or `reg_rd` strobe.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A STOP returns the block to idle with SDA released. After reset SDA is released and no strobe is active.
- R3: Each acknowledge pulls SDA low for the whole ninth clock of its byte. The block changes its SDA drive only while SCL is low.
- R4: In a write transfer, the first byte after the address always loads the pointer. The new pointer shows on `reg_addr`, and a pointer-only write produces no `reg_wr`.
- R5: The second byte of a write transfer produces one single-cycle `reg_wr`, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R6: A read transfer returns, MSB first, the `reg_rdata` value at the current pointer. No pointer byte is needed. The pointer persists across transfers. Exactly one single-cycle `reg_rd` is issued per data byte, in the cycle the byte is loaded for sending.
- R7: A repeated START directly after the acknowledge of a pointer write starts a new transfer. A read there returns the byte at the pointer just written.
- R8: While `alert_i` is high, a read to address byte 0x19 (alert response address 0x0C with the read bit) is acknowledged and returns 0x98. While `alert_i` is low, that address gets no acknowledge.
- R9: While sending, if the block leaves SDA released for a one bit and samples SDA low on the SCL rise, it stops driving SDA for the rest of the transfer.
- R10: If the host acknowledges a read data byte, the block sends a packet check byte next. This is CRC-8 with polynomial 0x07, initial value 0x00, MSB first, over the address byte and the data byte.
- R11: A third byte in a write transfer is acknowledged only if it equals CRC-8 over the address, pointer and data bytes. It never changes a register.
- R12: If no SCL edge occurs for TMO_CYCLES system clocks while a transfer is active, SDA is released and the block returns to idle. When `tmo_dis_i` is high, the block never does this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull SDA low when high |
| alert_i | input | 1 | Alert pending; enables the alert response reply |
| tmo_dis_i | input | 1 | Disables the inactivity timeout |
| reg_addr | output | 8 | Current address pointer |
| reg_wdata | output | 8 | Write data, valid with `reg_wr` |
| reg_wr | output | 1 | Single-cycle register write strobe |
| reg_rd | output | 1 | Single-cycle register read strobe |
| reg_rdata | input | 8 | Register read data for `reg_addr` |

## Verification
The bench builds the block with TMO_CYCLES set to 2000 and FILT_LEN set to 3. The short timeout lets both the release-on-silence case and the disabled case run within a few thousand clocks, while a normal bus bit of 48 clocks stays far below it. The short filter leaves roughly ten clocks of margin inside each quarter bit, so the slave drives SDA well before the host samples it. A second open-drain driver on the bench line creates the lost-arbitration case during an alert response read.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_RX, ST_TX, ST_TXACK, ST_SKIP
  } smb_st_t;

  // CRC-8, polynomial x^8+x^2+x+1, one byte, MSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/smb_filt.sv
module smb_filt #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == line_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        cnt_q  <= '0;
        line_o <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/smb_tmo.sv
module smb_tmo #(
  parameter int TMO_CYCLES = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic kick,
  input  logic en,
  output logic expire
);
  localparam int CW = $clog2(TMO_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!busy || kick) begin
      cnt_q <= '0;
    end else if (cnt_q != CW'(TMO_CYCLES)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire = en && busy && (cnt_q == CW'(TMO_CYCLES));
endmodule

// File: rtl/smb_fsm.sv
module smb_fsm
  import smb_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h4C,
  parameter logic [6:0] ARA_ADDR = 7'h0C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic       tmo_ev,
  input  logic       sda_f,
  input  logic       alert_i,
  input  logic [7:0] reg_rdata,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_wr,
  output logic       reg_rd,
  output logic       busy
);
  smb_st_t    st_q;
  logic [3:0] bitcnt_q;
  logic [7:0] sh_q;
  logic [7:0] tx_q;
  logic [7:0] crc_q;
  logic [7:0] ptr_q;
  logic [1:0] bidx_q;
  logic       rd_mode_q;
  logic       ara_q;
  logic       got_ack_q;
  logic [7:0] ld_byte;

  assign ld_byte  = ara_q ? {SLV_ADDR, 1'b0} : reg_rdata;
  assign reg_addr = ptr_q;
  assign busy     = (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      bitcnt_q  <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      crc_q     <= '0;
      ptr_q     <= '0;
      bidx_q    <= '0;
      rd_mode_q <= 1'b0;
      ara_q     <= 1'b0;
      got_ack_q <= 1'b0;
      sda_oe    <= 1'b0;
      reg_wdata <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (start_ev) begin
        st_q     <= ST_ADDR;
        bitcnt_q <= '0;
        bidx_q   <= '0;
        crc_q    <= '0;
        sda_oe   <= 1'b0;
      end else if (stop_ev || tmo_ev) begin
        st_q   <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (scl_rise && bitcnt_q < 4'd8) begin
              sh_q     <= {sh_q[6:0], sda_f};
              bitcnt_q <= bitcnt_q + 1'b1;
            end else if (scl_fall && bitcnt_q == 4'd8) begin
              crc_q     <= crc8_step(8'h00, sh_q);
              rd_mode_q <= sh_q[0];
              if (sh_q[7:1] == SLV_ADDR) begin
                ara_q  <= 1'b0;
                sda_oe <= 1'b1;
                st_q   <= ST_ACK;
              end else if (sh_q[7:1] == ARA_ADDR && sh_q[0] && alert_i) begin
                ara_q  <= 1'b1;
                sda_oe <= 1'b1;
                st_q   <= ST_ACK;
              end else begin
                st_q <= ST_SKIP;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt_q <= '0;
              if (rd_mode_q) begin
                tx_q   <= ld_byte;
                crc_q  <= crc8_step(crc_q, ld_byte);
                reg_rd <= !ara_q;
                sda_oe <= !ld_byte[7];
                bidx_q <= 2'd1;
                st_q   <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st_q   <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise && bitcnt_q < 4'd8) begin
              sh_q     <= {sh_q[6:0], sda_f};
              bitcnt_q <= bitcnt_q + 1'b1;
            end else if (scl_fall && bitcnt_q == 4'd8) begin
              st_q <= ST_ACK;
              unique case (bidx_q)
                2'd0: begin
                  ptr_q  <= sh_q;
                  crc_q  <= crc8_step(crc_q, sh_q);
                  sda_oe <= 1'b1;
                  bidx_q <= 2'd1;
                end
                2'd1: begin
                  reg_wr    <= 1'b1;
                  reg_wdata <= sh_q;
                  crc_q     <= crc8_step(crc_q, sh_q);
                  sda_oe    <= 1'b1;
                  bidx_q    <= 2'd2;
                end
                default: begin
                  sda_oe <= (sh_q == crc_q);
                end
              endcase
            end
          end
          ST_TX: begin
            if (scl_rise && !sda_oe && !sda_f) begin
              st_q <= ST_SKIP;
            end else if (scl_fall) begin
              if (bitcnt_q == 4'd7) begin
                sda_oe <= 1'b0;
                st_q   <= ST_TXACK;
              end else begin
                bitcnt_q <= bitcnt_q + 1'b1;
                tx_q     <= tx_q << 1;
                sda_oe   <= !tx_q[6];
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              got_ack_q <= !sda_f;
            end else if (scl_fall) begin
              if (got_ack_q && bidx_q == 2'd1) begin
                tx_q     <= crc_q;
                sda_oe   <= !crc_q[7];
                bitcnt_q <= '0;
                bidx_q   <= 2'd2;
                st_q     <= ST_TX;
              end else begin
                st_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_regslave.sv
module smb_regslave #(
  parameter logic [6:0] SLV_ADDR   = 7'h4C,
  parameter logic [6:0] ARA_ADDR   = 7'h0C,
  parameter int         FILT_LEN   = 4,
  parameter int         TMO_CYCLES = 2500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       alert_i,
  input  logic       tmo_dis_i,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_wr,
  output logic       reg_rd,
  input  logic [7:0] reg_rdata
);
  logic scl_f, sda_f, scl_q, sda_q;
  logic scl_rise, scl_fall, start_ev, stop_ev, tmo_ev, busy;
  logic [1:0] raw_lines, flt_lines;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    smb_filt #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .line_i(raw_lines[g]), .line_o(flt_lines[g])
    );
  end

  assign scl_f = flt_lines[1];
  assign sda_f = flt_lines[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f && !scl_q;
  assign scl_fall = !scl_f && scl_q;
  assign start_ev = scl_f && scl_q && sda_q && !sda_f;
  assign stop_ev  = scl_f && scl_q && !sda_q && sda_f;

  smb_tmo #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .kick(scl_rise || scl_fall || start_ev),
    .en(!tmo_dis_i), .expire(tmo_ev)
  );

  smb_fsm #(.SLV_ADDR(SLV_ADDR), .ARA_ADDR(ARA_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .tmo_ev(tmo_ev),
    .sda_f(sda_f), .alert_i(alert_i), .reg_rdata(reg_rdata),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .busy(busy)
  );
endmodule

// File: rtl/smb_regslave_chk.sv
module smb_regslave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic sda_oe,
  input logic reg_wr,
  input logic reg_rd,
  input logic stop_ev,
  input logic tmo_ev
);
  assert_drive_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  assert_tmo_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_ev |=> !sda_oe);

  assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  assert_rd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
endmodule

bind smb_regslave smb_regslave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe(sda_oe),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .stop_ev(stop_ev), .tmo_ev(tmo_ev)
);

// File: tb/sim_smb_regslave.sv
`timescale 1ns/1ps
module sim_smb_regslave;
  localparam int Q   = 16;
  localparam int TMO = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, oth_sda = 1'b1;
  logic alert = 1'b0, tmo_dis = 1'b0;
  logic sda_oe, reg_wr, reg_rd;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  wire  sda_line = m_sda & ~sda_oe & oth_sda;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit watch_oe = 1'b0, oe_seen = 1'b0;
  logic [15:0] wr_q [$];
  logic [7:0]  rd_q [$];

  always #2 clk = ~clk;

  assign reg_rdata = mem[reg_addr];

  smb_regslave #(.FILT_LEN(3), .TMO_CYCLES(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .alert_i(alert), .tmo_dis_i(tmo_dis), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  // scoreboard monitor: pops expected strobes as the design issues them
  always @(negedge clk) begin
    if (rst_n && reg_wr) begin
      if (wr_q.size() == 0) chk(0, "R5", "unexpected reg_wr", {reg_addr, reg_wdata}, 0);
      else begin
        logic [15:0] e;
        e = wr_q.pop_front();
        chk({reg_addr, reg_wdata} == e, "R5", "write addr/data", {reg_addr, reg_wdata}, e);
      end
      mem[reg_addr] = reg_wdata;
    end
    if (rst_n && reg_rd) begin
      if (rd_q.size() == 0) chk(0, "R6", "unexpected reg_rd", reg_addr, 0);
      else begin
        logic [7:0] e;
        e = rd_q.pop_front();
        chk(reg_addr == e, "R6", "read strobe addr", reg_addr, e);
      end
    end
    if (watch_oe && sda_oe) oe_seen = 1'b1;
  end

  task automatic wc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic m_start;
    m_sda = 1'b1; wc(Q); m_scl = 1'b1; wc(Q); m_sda = 1'b0; wc(Q); m_scl = 1'b0; wc(Q);
  endtask

  task automatic m_stop;
    m_sda = 1'b0; wc(Q); m_scl = 1'b1; wc(Q); m_sda = 1'b1; wc(Q);
  endtask

  task automatic m_bits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wc(Q); m_scl = 1'b1; wc(2*Q); m_scl = 1'b0;
    end
  endtask

  task automatic m_tx(input logic [7:0] b, output bit ack);
    m_bits(b);
    m_sda = 1'b1; wc(Q); m_scl = 1'b1; wc(Q); ack = !sda_line; wc(Q); m_scl = 1'b0;
  endtask

  task automatic m_rx(output logic [7:0] b, input bit give_ack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wc(Q); m_scl = 1'b1; wc(Q); b[i] = sda_line; wc(Q); m_scl = 1'b0;
    end
    m_sda = give_ack ? 1'b0 : 1'b1; wc(Q); m_scl = 1'b1; wc(2*Q); m_scl = 1'b0;
  endtask

  // driver: one write-byte transfer, expected strobe pushed to the scoreboard
  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    bit k;
    wr_q.push_back({a, d});
    m_start;
    m_tx(8'h98, k); chk(k, "R1", "ack of 0x98", k, 1);
    m_tx(a, k);     chk(k, "R4", "ack of pointer byte", k, 1);
    m_tx(d, k);     chk(k, "R5", "ack of data byte", k, 1);
    m_stop;
  endtask

  task automatic do_read(input logic [7:0] a, input string req);
    bit k;
    logic [7:0] b;
    rd_q.push_back(a);
    m_start;
    m_tx(8'h99, k); chk(k, "R1", "ack of 0x99", k, 1);
    m_rx(b, 1'b0);  chk(b == mem[a], req, "read data", b, mem[a]);
    m_stop;
  endtask

  initial begin
    bit k;
    logic [7:0] b, c;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    wc(5);
    rst_n = 1'b1;
    wc(5);
    chk(!sda_oe && !reg_wr && !reg_rd, "R2", "reset outputs", {sda_oe, reg_wr, reg_rd}, 0);

    // R5 write byte transfers
    do_write(8'h10, 8'hA5);
    do_write(8'h11, 8'h3C);

    // R4 pointer-only write (send byte)
    m_start;
    m_tx(8'h98, k); chk(k, "R1", "ack of 0x98", k, 1);
    m_tx(8'h20, k); chk(k, "R4", "ack of pointer", k, 1);
    m_stop;
    chk(reg_addr == 8'h20, "R4", "pointer on reg_addr", reg_addr, 8'h20);

    // R6 receive byte twice at the persistent pointer
    do_read(8'h20, "R6");
    do_read(8'h20, "R6");
    chk(reg_addr == 8'h20, "R6", "pointer persists", reg_addr, 8'h20);

    // R7 pointer write, repeated START, read
    rd_q.push_back(8'h10);
    m_start;
    m_tx(8'h98, k); m_tx(8'h10, k);
    m_start;
    m_tx(8'h99, k); chk(k, "R7", "ack after repeated start", k, 1);
    m_rx(b, 1'b0);  chk(b == 8'hA5, "R7", "read after repeated start", b, 8'hA5);
    m_stop;

    // R1 foreign address ignored
    m_start;
    m_tx(8'hA0, k); chk(!k, "R1", "no ack for 0xA0", k, 0);
    m_tx(8'h10, k); chk(!k, "R1", "no ack for following byte", k, 0);
    m_stop;
    chk(reg_addr == 8'h10, "R1", "pointer untouched", reg_addr, 8'h10);

    // R10 read with packet check byte
    rd_q.push_back(8'h10);
    m_start;
    m_tx(8'h99, k);
    m_rx(b, 1'b1);
    m_rx(c, 1'b0);
    m_stop;
    chk(b == 8'hA5, "R10", "data before check byte", b, 8'hA5);
    chk(c == ref_crc(ref_crc(8'h00, 8'h99), 8'hA5), "R10", "read check byte", c,
        ref_crc(ref_crc(8'h00, 8'h99), 8'hA5));

    // R8 alert response with check byte
    alert = 1'b1;
    m_start;
    m_tx(8'h19, k); chk(k, "R8", "ack of alert response address", k, 1);
    m_rx(b, 1'b1);  chk(b == 8'h98, "R8", "alert reply", b, 8'h98);
    m_rx(c, 1'b0);
    chk(c == ref_crc(ref_crc(8'h00, 8'h19), 8'h98), "R10", "alert check byte", c,
        ref_crc(ref_crc(8'h00, 8'h19), 8'h98));
    m_stop;
    alert = 1'b0;
    m_start;
    m_tx(8'h19, k); chk(!k, "R8", "no ack without alert", k, 0);
    m_stop;

    // R9 lost arbitration during alert reply
    alert = 1'b1;
    m_start;
    m_tx(8'h19, k);
    oth_sda = 1'b0;
    wc(Q/2);
    watch_oe = 1'b1;
    m_rx(b, 1'b0);
    watch_oe = 1'b0;
    oth_sda = 1'b1;
    m_stop;
    alert = 1'b0;
    chk(!oe_seen, "R9", "no drive after lost arbitration", oe_seen, 0);
    chk(b == 8'h00, "R9", "bus byte after loss", b, 8'h00);

    // R11 write with check byte, good and bad
    c = ref_crc(ref_crc(ref_crc(8'h00, 8'h98), 8'h30), 8'h77);
    wr_q.push_back({8'h30, 8'h77});
    m_start;
    m_tx(8'h98, k); m_tx(8'h30, k); m_tx(8'h77, k);
    m_tx(c, k); chk(k, "R11", "ack of correct check byte", k, 1);
    m_stop;
    wr_q.push_back({8'h31, 8'h01});
    m_start;
    m_tx(8'h98, k); m_tx(8'h31, k); m_tx(8'h01, k);
    m_tx(8'h00, k); chk(!k, "R11", "nack of wrong check byte", k, 0);
    m_stop;
    rd_q.push_back(8'h31);
    m_start;
    m_tx(8'h99, k);
    m_rx(b, 1'b0);
    m_stop;
    chk(b == 8'h01, "R11", "check byte does not write", b, 8'h01);

    // R12 timeout while acknowledge is held
    m_start;
    m_bits(8'h98);
    wc(TMO / 2);
    chk(sda_oe, "R3", "ack held during low", sda_oe, 1);
    wc(TMO);
    chk(!sda_oe, "R12", "released after timeout", sda_oe, 0);
    m_scl = 1'b1; wc(Q); m_scl = 1'b0; wc(Q);
    m_stop;
    tmo_dis = 1'b1;
    m_start;
    m_bits(8'h98);
    wc(TMO + 200);
    chk(sda_oe, "R12", "held with timeout disabled", sda_oe, 1);
    m_sda = 1'b1; wc(Q); m_scl = 1'b1; wc(Q); m_scl = 1'b0; wc(Q);
    m_stop;
    tmo_dis = 1'b0;
    chk(!sda_oe, "R2", "released after stop", sda_oe, 0);

    do_write(8'h40, 8'hC3);
    do_read(8'h40, "R12");

    wc(10);
    chk(wr_q.size() == 0, "R5", "writes outstanding", wr_q.size(), 0);
    chk(rd_q.size() == 0, "R6", "reads outstanding", rd_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule